// File: doc/BRIEF.md
# Boot Mode Entry Sequence Detector

This block decides, on every release of the external reset pin, whether the core should fetch its start address from the normal reset vector or from the bootloader vector. While the reset pin is held low it counts qualifying transitions on a separate strobe pin. At the instant the reset pin is seen going high it checks the strobe level and a set of inhibit conditions, then raises exactly one of two single-cycle indications: `boot_start` or `normal_start`.

Both pins are asynchronous to the core clock and pass through synchronizer chains before any edge is detected. A parameter picks the pin variant. In the shared-pin variant the strobe must make rising transitions and be high at release. In the dedicated-pin variant the strobe must make falling transitions and be low at release. The shared-pin variant also produces `test_mode`, the internal signal that hands the shared pins over to the debug function. It is forced low once the entry sequence has been recognised, so the pins stay in application mode.

Top module: `boot_entry_detect`

## Requirements
- R1: Shared variant (VARIANT = VAR_SHARED, value 0): `boot_start` pulses on a reset-pin release when at least two rising strobe transitions were seen while the reset pin was low and the strobe is high at release.
- R2: Dedicated variant (VARIANT = VAR_DEDICATED, value 1): `boot_start` pulses on a release when at least two falling strobe transitions were seen while the reset pin was low and the strobe is low at release.
- R3: If the strobe is at the wrong level for the variant at release, `normal_start` pulses instead of `boot_start`, whatever the transition count.
- R4: With fewer than two qualifying transitions in the reset-low window, the release gives `normal_start`.
- R5: The release gives `normal_start` when `dbg_owns` or `nmi_mode` is high in the release cycle, or when `por_event` was high at any time since the last falling edge of the reset pin. A later reset-low window without `por_event` may boot again.
- R6: The transition count stops at two, so extra transitions still qualify. It is cleared at each falling edge of the reset pin, so transitions from an earlier window do not carry over. Strobe transitions while the reset pin is high are not counted.
- R7: Each release of the reset pin gives exactly one pulse, one clock long, on exactly one of `boot_start` and `normal_start`. When the reset pin changes before clock edge A, the pulse is high in the cycle after edge A+2. Nothing pulses while the reset pin stays low.
- R8: Shared variant: `test_mode` equals the synchronized strobe (two-clock latency). It is held low from the moment the second rising transition is counted until the next falling edge of the reset pin. Dedicated variant: `test_mode` is constantly 0.
- R9: While `arst_n` is low, `boot_start`, `normal_start` and `test_mode` are 0 and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low reset of the detector itself |
| rst_pin_n | input | 1 | External active-low reset pin (asynchronous) |
| strobe_pin | input | 1 | Test / clock strobe pin (asynchronous) |
| dbg_owns | input | 1 | Debug port currently owns the device (synchronous) |
| por_event | input | 1 | Power-on reset occurred (synchronous pulse or level) |
| nmi_mode | input | 1 | Reset pin is configured as an NMI input (synchronous) |
| boot_start | output | 1 | One-cycle pulse: start at the bootloader vector |
| normal_start | output | 1 | One-cycle pulse: start at the normal reset vector |
| test_mode | output | 1 | Shared variant: pins switched to the debug function |

## Verification
The assertions take the inhibit inputs to be synchronous to `clk` and sample them in the release cycle. They also take pin edges to be far enough apart that the synchronized reset pin cannot rise on two adjacent clocks. The bench follows both rules: it changes the inhibit inputs only on the falling clock edge and holds them stable across each release. It keeps every pin level for at least three clocks. It never moves the strobe in the same cycle that the synchronized reset pin falls, so the clear and count rules are never tested against each other.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

    typedef enum logic {
        VAR_SHARED    = 1'b0,
        VAR_DEDICATED = 1'b1
    } pin_variant_e;

    typedef struct packed {
        logic boot;
        logic normal;
        logic por_seen;
    } decide_state_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] chain_d [DEPTH];
    logic [WIDTH-1:0] chain_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb chain_d[g] = async_i;
        end else begin : g_next
            always_comb chain_d[g] = chain_q[g-1];
        end

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain_q[g] <= RESET_VAL;
            else         chain_q[g] <= chain_d[g];
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/edge_tally.sv
module edge_tally #(
    parameter int EDGE_TARGET = 2,
    parameter bit FALLING     = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic strobe_s,
    input  logic strobe_prev,
    input  logic rst_low,
    input  logic clear,
    output logic reached_o
);
    localparam int CNT_W = $clog2(EDGE_TARGET + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_t;

    tally_t tally_d, tally_q;
    logic   qual_edge;

    assign qual_edge = FALLING ? (~strobe_s & strobe_prev) : (strobe_s & ~strobe_prev);

    always_comb begin
        tally_d = tally_q;
        if (clear) begin
            tally_d.cnt = '0;
        end else if (qual_edge && rst_low && (tally_q.cnt != CNT_W'(EDGE_TARGET))) begin
            tally_d.cnt = tally_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) tally_q <= '0;
        else         tally_q <= tally_d;
    end

    assign reached_o = (tally_q.cnt == CNT_W'(EDGE_TARGET));

    AST_TALLY_SATURATE: assert property (@(posedge clk) disable iff (!arst_n)
        (reached_o && !clear) |=> reached_o); // R6
    AST_TALLY_FROZEN_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
        (!rst_low && !clear) |=> $stable(tally_q.cnt)); // R6

endmodule

// File: rtl/boot_entry_detect.sv
module boot_entry_detect
    import boot_entry_pkg::*;
#(
    parameter pin_variant_e VARIANT     = VAR_SHARED,
    parameter int           EDGE_TARGET = 2,
    parameter int           SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin_n,
    input  logic strobe_pin,
    input  logic dbg_owns,
    input  logic por_event,
    input  logic nmi_mode,
    output logic boot_start,
    output logic normal_start,
    output logic test_mode
);
    localparam logic STROBE_IDLE = (VARIANT == VAR_DEDICATED);

    logic [1:0] pins_s, pins_prev;
    logic       rst_s, rst_prev, strobe_s, strobe_prev;
    logic       rel_rise, rel_fall, level_ok, reached, por_hit, boot_ok;
    decide_state_t st_d, st_q;

    pin_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({STROBE_IDLE, 1'b1})
    ) u_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .async_i ({strobe_pin, rst_pin_n}),
        .sync_o  (pins_s),
        .prev_o  (pins_prev)
    );

    assign rst_s       = pins_s[0];
    assign rst_prev    = pins_prev[0];
    assign strobe_s    = pins_s[1];
    assign strobe_prev = pins_prev[1];

    assign rel_rise = rst_s & ~rst_prev;
    assign rel_fall = ~rst_s & rst_prev;

    edge_tally #(
        .EDGE_TARGET (EDGE_TARGET),
        .FALLING     (VARIANT == VAR_DEDICATED)
    ) u_tally (
        .clk         (clk),
        .arst_n      (arst_n),
        .strobe_s    (strobe_s),
        .strobe_prev (strobe_prev),
        .rst_low     (~rst_s),
        .clear       (rel_fall),
        .reached_o   (reached)
    );

    assign level_ok = (VARIANT == VAR_DEDICATED) ? ~strobe_s : strobe_s;
    assign por_hit  = por_event | st_q.por_seen;
    assign boot_ok  = rel_rise & reached & level_ok & ~dbg_owns & ~nmi_mode & ~por_hit;

    always_comb begin
        st_d = st_q;
        if (por_event)     st_d.por_seen = 1'b1;
        else if (rel_fall) st_d.por_seen = 1'b0;
        st_d.boot   = boot_ok;
        st_d.normal = rel_rise & ~boot_ok;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign boot_start   = st_q.boot;
    assign normal_start = st_q.normal;

    if (VARIANT == VAR_SHARED) begin : g_shared_tm
        assign test_mode = strobe_s & ~reached;
    end else begin : g_dedicated_tm
        assign test_mode = 1'b0;
    end

    AST_EXCLUSIVE_START: assert property (@(posedge clk) disable iff (!arst_n)
        !(boot_start && normal_start)); // R7
    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
        (boot_start || normal_start) |=> !(boot_start || normal_start)); // R7
    AST_QUIET_WHILE_LOW: assert property (@(posedge clk) disable iff (!arst_n)
        !rst_s |=> !(boot_start || normal_start)); // R7
    AST_BOOT_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!arst_n)
        boot_start |-> $past(reached)); // R4
    AST_BOOT_LEVEL: assert property (@(posedge clk) disable iff (!arst_n)
        boot_start |-> $past(level_ok)); // R3
    AST_BOOT_INHIBIT: assert property (@(posedge clk) disable iff (!arst_n)
        boot_start |-> (!$past(dbg_owns) && !$past(nmi_mode) && !$past(por_event))); // R5

endmodule

// File: tb/boot_entry_detect_test.sv
`timescale 1ns/1ps
module boot_entry_detect_test;
    import boot_entry_pkg::*;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic rst_pin_n = 1'b1;
    logic strobe_sh = 1'b0;
    logic strobe_dp = 1'b1;
    logic dbg = 1'b0, por = 1'b0, nmi = 1'b0;
    logic boot_sh, norm_sh, tm_sh, boot_dp, norm_dp, tm_dp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    boot_entry_detect #(.VARIANT(VAR_SHARED)) uut (
        .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n), .strobe_pin(strobe_sh),
        .dbg_owns(dbg), .por_event(por), .nmi_mode(nmi),
        .boot_start(boot_sh), .normal_start(norm_sh), .test_mode(tm_sh));

    boot_entry_detect #(.VARIANT(VAR_DEDICATED)) uut_dp (
        .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n), .strobe_pin(strobe_dp),
        .dbg_owns(dbg), .por_event(por), .nmi_mode(nmi),
        .boot_start(boot_dp), .normal_start(norm_dp), .test_mode(tm_dp));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: pin histories and a per-window transition count.
    bit r1, r2, rp, porf, started;
    bit s1 [2];
    bit s2 [2];
    bit sp [2];
    int cnt [2];
    bit eb [2];
    bit en [2];
    bit et [2];

    always @(posedge clk) begin
        bit pin_in [2];
        bit rise, fall, edge_seen, lvl;
        pin_in[0] = strobe_sh;
        pin_in[1] = strobe_dp;
        if (!arst_n) begin
            r1 = 1; r2 = 1; rp = 1; porf = 0;
            for (int v = 0; v < 2; v++) begin
                s1[v] = (v == 1); s2[v] = (v == 1); sp[v] = (v == 1);
                cnt[v] = 0; eb[v] = 0; en[v] = 0; et[v] = 0;
            end
        end else begin
            rise = r2 && !rp;
            fall = !r2 && rp;
            for (int v = 0; v < 2; v++) begin
                edge_seen = (v == 0) ? (s2[v] && !sp[v]) : (!s2[v] && sp[v]);
                lvl       = (v == 0) ? s2[v] : !s2[v];
                eb[v] = rise && cnt[v] >= 2 && lvl && !dbg && !nmi && !(porf || por);
                en[v] = rise && !eb[v];
                if (fall) cnt[v] = 0;
                else if (edge_seen && !r2 && cnt[v] < 2) cnt[v]++;
                sp[v] = s2[v]; s2[v] = s1[v]; s1[v] = pin_in[v];
                et[v] = (v == 0) ? (s2[v] && cnt[v] < 2) : 1'b0;
            end
            if (por) porf = 1;
            else if (fall) porf = 0;
            rp = r2; r2 = r1; r1 = rst_pin_n;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check(boot_sh === eb[0], "R7 boot shared", int'(boot_sh), int'(eb[0]));
            check(norm_sh === en[0], "R7 normal shared", int'(norm_sh), int'(en[0]));
            check(tm_sh === et[0], "R8 test_mode shared", int'(tm_sh), int'(et[0]));
            check(boot_dp === eb[1], "R7 boot dedicated", int'(boot_dp), int'(eb[1]));
            check(norm_dp === en[1], "R7 normal dedicated", int'(norm_dp), int'(en[1]));
            check(tm_dp === et[1], "R8 test_mode dedicated", int'(tm_dp), int'(et[1]));
        end
    end

    task automatic session(input int pulses, input bit at_level, input bit d, input bit n,
                           input bit p, input bit exp_boot, input bit exp_tm, input string req);
        int first;
        int nb0, nn0, nb1, nn1;
        first = -1; nb0 = 0; nn0 = 0; nb1 = 0; nn1 = 0;
        @(negedge clk) rst_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < pulses; i++) begin
            strobe_sh = 1'b1; strobe_dp = 1'b0;
            repeat (3) @(negedge clk);
            strobe_sh = 1'b0; strobe_dp = 1'b1;
            repeat (3) @(negedge clk);
        end
        if (at_level) begin
            strobe_sh = 1'b1; strobe_dp = 1'b0;
            repeat (3) @(negedge clk);
        end
        if (p) begin
            por = 1'b1;
            @(negedge clk) por = 1'b0;
            repeat (3) @(negedge clk);
        end
        dbg = d; nmi = n;
        @(negedge clk) rst_pin_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if ((boot_sh || norm_sh) && first < 0) first = k;
            nb0 += int'(boot_sh); nn0 += int'(norm_sh);
            nb1 += int'(boot_dp); nn1 += int'(norm_dp);
        end
        check(nb0 == int'(exp_boot), {req, " shared boot count"}, nb0, int'(exp_boot));
        check(nn0 == int'(!exp_boot), {req, " shared normal count"}, nn0, int'(!exp_boot));
        check(nb1 == int'(exp_boot), {req, " dedicated boot count"}, nb1, int'(exp_boot));
        check(nn1 == int'(!exp_boot), {req, " dedicated normal count"}, nn1, int'(!exp_boot));
        check(first == 3, "R7 release-to-pulse latency", first, 3);
        check(tm_sh == exp_tm, "R8 shared test_mode after release", int'(tm_sh), int'(exp_tm));
        check(tm_dp == 1'b0, "R8 dedicated test_mode", int'(tm_dp), 0);
        dbg = 1'b0; nmi = 1'b0;
        strobe_sh = 1'b0; strobe_dp = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!boot_sh && !norm_sh && !tm_sh, "R9 reset state shared",
              int'({boot_sh, norm_sh, tm_sh}), 0);
        check(!boot_dp && !norm_dp && !tm_dp, "R9 reset state dedicated",
              int'({boot_dp, norm_dp, tm_dp}), 0);
        arst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!boot_sh && !norm_sh, "R9 quiet after reset", int'({boot_sh, norm_sh}), 0);

        session(1, 1, 0, 0, 0, 1, 0, "R1,R2");     // two qualifying transitions, right level
        session(2, 0, 0, 0, 0, 0, 0, "R3");        // enough transitions, wrong level
        session(0, 1, 0, 0, 0, 0, 1, "R4,R6");     // one transition; earlier window cleared
        session(0, 0, 0, 0, 0, 0, 0, "R4");        // no transitions
        session(4, 1, 0, 0, 0, 1, 0, "R6");        // saturating count still boots
        session(1, 1, 1, 0, 0, 0, 0, "R5 debug");  // debug port owns the device
        session(1, 1, 0, 1, 0, 0, 0, "R5 nmi");    // reset pin in NMI mode
        session(1, 1, 0, 0, 1, 0, 0, "R5 por");    // power-on reset seen in window
        session(1, 1, 0, 0, 0, 1, 0, "R1,R5");     // inhibit flag gone in new window

        // R6: strobe transitions while the reset pin is high are not counted
        for (int i = 0; i < 3; i++) begin
            strobe_sh = 1'b1; strobe_dp = 1'b0; repeat (3) @(negedge clk);
            strobe_sh = 1'b0; strobe_dp = 1'b1; repeat (3) @(negedge clk);
        end
        session(0, 0, 0, 0, 0, 0, 0, "R6 high-window edges");

        // R7: nothing pulses while the reset pin stays low
        @(negedge clk) rst_pin_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k == 10) begin strobe_sh = 1'b1; strobe_dp = 1'b0; end
            if (k > 3)
                check(!boot_sh && !norm_sh && !boot_dp && !norm_dp, "R7 quiet while low",
                      int'({boot_sh, norm_sh, boot_dp, norm_dp}), 0);
        end
        rst_pin_n = 1'b1;
        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule